// File: doc/BRIEF.md
# Dual-Clock Dual-Port Synchronous RAM

A true dual-port synchronous memory with two fully independent ports, A and B, each running on its own clock. Both ports may reach any word at any time, including the same word together. On each rising edge of its clock a port registers its address, write data, read/write control and a pair of chip selects. One select is active low and the other is active high, so that banks of these blocks can be stacked in depth without extra decode. The port-level output enable is asynchronous. In place of a tri-state pad, each port drives a 9-bit read bus together with a drive flag.

A static mode pin on each port chooses how reads are returned. In direct mode the word appears in the cycle that follows the edge that registered the read address. In registered mode the word passes through one more register and appears a cycle later. A small per-port state machine follows consecutive selected reads and decides when the drive flag may rise.

The machine has three states:
- `ST_IDLE`: no read registered.
- `ST_FILL`: one read registered; the registered-mode output is still filling.
- `ST_STREAM`: two or more back-to-back reads registered.

Its transitions are:
- idle-to-fill: a selected read is sampled in `ST_IDLE`.
- fill-to-stream: a selected read is sampled in `ST_FILL`.
- stream-hold: a selected read is sampled in `ST_STREAM`.
- any-to-idle: a write, a deselect or a reset is sampled in any state.

Memory depth is `2**ADDR_W` words of `DATA_W` bits. The full-size part uses `ADDR_W = 14` (16K words) and `DATA_W = 9`. The default `ADDR_W` of 11 keeps elaboration small.

Top module: `dpram_dual_clk`

## Requirements
- R1: A port is selected at a rising edge only when its `cs0_n` is 0 and its `cs1` is 1. At an edge with any other select combination, the write data is ignored: a later read of that address returns the old word. The port's drive flag is 0 for the whole cycle after that edge.
- R2: At an edge where the port is selected and `rnw` is 0, `wdata` is stored at `addr`. The drive flag is 0 for the cycle after that edge, whatever the mode.
- R3: In direct mode (`pipe` = 0), a selected read (`rnw` = 1) sampled at an edge makes `rdata` equal to the word at that address in the following cycle. With `oe_n` = 0, the drive flag is 1 in that cycle.
- R4: In registered mode (`pipe` = 1), the word read at edge k is presented after edge k+1. The drive flag is 1 only after the second of two back-to-back selected read edges. After any write or deselect edge it is 0, and it stays 0 after the next read edge.
- R5: `oe_n` = 1 forces the drive flag to 0 at once, with no clock edge. Setting `oe_n` back to 0 restores the flag within the same cycle.
- R6: In registered mode, `rdata` keeps its last value across edges at which the state machine is in `ST_IDLE`.
- R7: A word written through one port is returned by the other port from that port's next read edge onward. The two ports run on unrelated clocks.
- R8: Each port's mode pin acts on its own port alone and acts without a clock. With the state held, changing `pipe` switches `rdata` between the registered word and the word at the registered address.
- R9: After reset both drive flags are 0. Address 0 and address `2**ADDR_W-1` each hold their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_cs0_n | input | 1 | Port A select, active low |
| a_cs1 | input | 1 | Port A select, active high |
| a_rnw | input | 1 | Port A read (1) or write (0) |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A mode: 0 direct, 1 registered |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_drive | output | 1 | Port A output drive flag |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_cs0_n | input | 1 | Port B select, active low |
| b_cs1 | input | 1 | Port B select, active high |
| b_rnw | input | 1 | Port B read (1) or write (0) |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B mode: 0 direct, 1 registered |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_drive | output | 1 | Port B output drive flag |

## Verification
The assertions assume that each mode pin changes only between edges and is back at a steady value by the next edge of its port. They also assume that the two ports never write one address at edges falling in the same time step. The stimulus changes inputs only on the falling edge of the port's own clock, or within a short window just after a rising edge. It offsets port B's clock by 3 ns from port A's, so the edges of the two ports never coincide. Every write address is used by one port at a time.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;

    // Read-side state of one port.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2
    } rd_state_e;

    // Read taps on each storage bank.
    localparam int TAP_A    = 0;   // port A registered address
    localparam int TAP_B    = 1;   // port B registered address
    localparam int TAP_PEER = 2;   // the other bank's write address
    localparam int NTAP     = 3;

endpackage

// File: rtl/dpram_bank.sv
`timescale 1ns/1ps
// One storage bank with a single writer and several asynchronous read taps.
module dpram_bank #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9,
    parameter int NRD    = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_tap
        assign rdata[g] = cells[raddr[g]];
    end
endmodule

// File: rtl/dpram_port.sv
`timescale 1ns/1ps
// Per-port control: select decode, read state machine, output register and drive flag.
module dpram_port
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              rnw,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_now,
    output logic [DATA_W-1:0] rdata,
    output logic              drive
);
    logic                sel_now;
    logic                rd_now;
    logic                src_valid;
    rd_state_e           state_q;
    rd_state_e           state_d;
    logic [DATA_W-1:0]   pipe_q;

    assign sel_now = !cs0_n && cs1;
    assign rd_now  = sel_now && rnw;
    assign wr_now  = sel_now && !rnw;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:   state_d = rd_now ? ST_FILL : ST_IDLE;
            ST_FILL:   state_d = rd_now ? ST_STREAM : ST_IDLE;
            ST_STREAM: state_d = rd_now ? ST_STREAM : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Address register and registered-mode output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            pipe_q <= '0;
        end else begin
            addr_q <= addr;
            if (state_q != ST_IDLE) begin
                pipe_q <= mem_rdata;
            end
        end
    end

    // Outputs.
    always_comb begin
        src_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   src_valid = 1'b0;
            ST_FILL:   src_valid = !pipe;
            ST_STREAM: src_valid = 1'b1;
            default:   src_valid = 1'b0;
        endcase
        drive = src_valid && !oe_n;
        rdata = pipe ? pipe_q : mem_rdata;
    end

    // R1: a deselected edge leaves the drive flag low for the next cycle.
    a_r1_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_now |=> !drive);

    // R2: a write edge leaves the drive flag low for the next cycle.
    a_r2_write_off: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> !drive);

    // R3: a direct-mode read with output enabled drives in the next cycle.
    a_r3_direct_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && !pipe && !oe_n) |=> (pipe || oe_n || drive));

    // R4: registered mode cannot drive one edge after an idle state.
    a_r4_warmup: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && state_q == ST_IDLE) |=> (!pipe || !drive));

    // R6: the registered output keeps its value across an idle edge.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe && state_q == ST_IDLE) |=> (!pipe || $stable(rdata)));
endmodule

// File: rtl/dpram_dual_clk.sv
`timescale 1ns/1ps
// Two-clock true dual-port RAM built from two single-writer banks combined by XOR.
module dpram_dual_clk
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              a_clk,
    input  logic              a_rst_n,
    input  logic              a_cs0_n,
    input  logic              a_cs1,
    input  logic              a_rnw,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_drive,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic              b_cs0_n,
    input  logic              b_cs1,
    input  logic              b_rnw,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_drive
);
    logic [ADDR_W-1:0] a_addr_q, b_addr_q;
    logic              a_wr, b_wr;
    logic [DATA_W-1:0] a_mem, b_mem;
    logic [DATA_W-1:0] a_bank_wdata, b_bank_wdata;
    logic [ADDR_W-1:0] ka_raddr [NTAP];
    logic [ADDR_W-1:0] kb_raddr [NTAP];
    logic [DATA_W-1:0] ka_rdata [NTAP];
    logic [DATA_W-1:0] kb_rdata [NTAP];

    assign ka_raddr[TAP_A]    = a_addr_q;
    assign ka_raddr[TAP_B]    = b_addr_q;
    assign ka_raddr[TAP_PEER] = b_addr;
    assign kb_raddr[TAP_A]    = a_addr_q;
    assign kb_raddr[TAP_B]    = b_addr_q;
    assign kb_raddr[TAP_PEER] = a_addr;

    // Each bank stores data XOR the other bank, so the XOR of both is the word.
    assign a_bank_wdata = a_wdata ^ kb_rdata[TAP_PEER];
    assign b_bank_wdata = b_wdata ^ ka_rdata[TAP_PEER];
    assign a_mem        = ka_rdata[TAP_A] ^ kb_rdata[TAP_A];
    assign b_mem        = ka_rdata[TAP_B] ^ kb_rdata[TAP_B];

    dpram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NTAP)) u_bank_a (
        .clk(a_clk), .we(a_wr), .waddr(a_addr), .wdata(a_bank_wdata),
        .raddr(ka_raddr), .rdata(ka_rdata)
    );

    dpram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NTAP)) u_bank_b (
        .clk(b_clk), .we(b_wr), .waddr(b_addr), .wdata(b_bank_wdata),
        .raddr(kb_raddr), .rdata(kb_rdata)
    );

    dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
        .clk(a_clk), .rst_n(a_rst_n), .cs0_n(a_cs0_n), .cs1(a_cs1),
        .rnw(a_rnw), .oe_n(a_oe_n), .pipe(a_pipe), .addr(a_addr),
        .mem_rdata(a_mem), .addr_q(a_addr_q), .wr_now(a_wr),
        .rdata(a_rdata), .drive(a_drive)
    );

    dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
        .clk(b_clk), .rst_n(b_rst_n), .cs0_n(b_cs0_n), .cs1(b_cs1),
        .rnw(b_rnw), .oe_n(b_oe_n), .pipe(b_pipe), .addr(b_addr),
        .mem_rdata(b_mem), .addr_q(b_addr_q), .wr_now(b_wr),
        .rdata(b_rdata), .drive(b_drive)
    );
endmodule

// File: tb/sim_dpram_dual_clk.sv
`timescale 1ns/1ps
module sim_dpram_dual_clk;
    localparam int AW = 11;
    localparam int DW = 9;

    logic a_clk, a_rst_n, a_cs0_n, a_cs1, a_rnw, a_oe_n, a_pipe, a_drive;
    logic b_clk, b_rst_n, b_cs0_n, b_cs1, b_rnw, b_oe_n, b_pipe, b_drive;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

    int checks = 0;
    int errors = 0;

    dpram_dual_clk #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .a_clk(a_clk), .a_rst_n(a_rst_n), .a_cs0_n(a_cs0_n), .a_cs1(a_cs1),
        .a_rnw(a_rnw), .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drive(a_drive),
        .b_clk(b_clk), .b_rst_n(b_rst_n), .b_cs0_n(b_cs0_n), .b_cs1(b_cs1),
        .b_rnw(b_rnw), .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drive(b_drive)
    );

    // 125 MHz on both ports; port B is phase shifted by 3 ns.
    initial a_clk = 1'b0;
    always #4 a_clk = ~a_clk;
    initial begin
        b_clk = 1'b0;
        #3;
        forever #4 b_clk = ~b_clk;
    end

    typedef struct packed {
        logic          cs0_n;
        logic          cs1;
        logic          rnw;
        logic          oe_n;
        logic          pipe;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic          exp_drv;
        logic          chk_dat;
        logic [DW-1:0] exp_dat;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,11'd5,9'h1A5,1'b0,1'b0,9'h000,4'd2}, // R2 write
        '{1'b0,1'b1,1'b0,1'b0,1'b0,11'd6,9'h0C3,1'b0,1'b0,9'h000,4'd2}, // R2 write
        '{1'b0,1'b1,1'b1,1'b0,1'b0,11'd5,9'h000,1'b1,1'b1,9'h1A5,4'd3}, // R3 direct read
        '{1'b0,1'b1,1'b1,1'b0,1'b0,11'd6,9'h000,1'b1,1'b1,9'h0C3,4'd3}, // R3 direct read
        '{1'b1,1'b1,1'b0,1'b0,1'b0,11'd5,9'h055,1'b0,1'b0,9'h000,4'd1}, // R1 cs0_n high
        '{1'b0,1'b1,1'b1,1'b0,1'b0,11'd5,9'h000,1'b1,1'b1,9'h1A5,4'd1}, // R1 write ignored
        '{1'b0,1'b0,1'b0,1'b0,1'b0,11'd5,9'h077,1'b0,1'b0,9'h000,4'd1}, // R1 cs1 low
        '{1'b0,1'b1,1'b1,1'b1,1'b0,11'd5,9'h000,1'b0,1'b0,9'h000,4'd5}, // R5 oe_n high
        '{1'b0,1'b1,1'b1,1'b0,1'b0,11'd5,9'h000,1'b1,1'b1,9'h1A5,4'd1}, // R1 write ignored
        '{1'b0,1'b1,1'b1,1'b0,1'b1,11'd6,9'h000,1'b1,1'b1,9'h1A5,4'd4}, // R4 one cycle later
        '{1'b0,1'b1,1'b1,1'b0,1'b1,11'd5,9'h000,1'b1,1'b1,9'h0C3,4'd4}, // R4
        '{1'b1,1'b0,1'b1,1'b0,1'b1,11'd5,9'h000,1'b0,1'b1,9'h1A5,4'd1}, // R1 deselect
        '{1'b1,1'b0,1'b1,1'b0,1'b1,11'd5,9'h000,1'b0,1'b1,9'h1A5,4'd6}, // R6 hold
        '{1'b0,1'b1,1'b1,1'b0,1'b1,11'd6,9'h000,1'b0,1'b1,9'h1A5,4'd4}, // R4 warm-up, R6 hold
        '{1'b0,1'b1,1'b1,1'b0,1'b1,11'd5,9'h000,1'b1,1'b1,9'h0C3,4'd4}, // R4 second read
        '{1'b0,1'b1,1'b0,1'b0,1'b1,11'd7,9'h1FF,1'b0,1'b1,9'h1A5,4'd2}, // R2 registered write
        '{1'b0,1'b1,1'b1,1'b0,1'b1,11'd7,9'h000,1'b0,1'b1,9'h1A5,4'd6}, // R6 hold
        '{1'b0,1'b1,1'b1,1'b0,1'b1,11'd7,9'h000,1'b1,1'b1,9'h1FF,4'd4}  // R4
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic a_op(input logic cs0n, input logic cs1, input logic rnw, input logic oen,
                        input logic pp, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
        @(negedge a_clk);
        a_cs0_n = cs0n; a_cs1 = cs1; a_rnw = rnw; a_oe_n = oen;
        a_pipe = pp; a_addr = ad; a_wdata = wd;
        @(posedge a_clk);
        #1;
    endtask

    task automatic b_op(input logic cs0n, input logic cs1, input logic rnw, input logic oen,
                        input logic pp, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
        @(negedge b_clk);
        b_cs0_n = cs0n; b_cs1 = cs1; b_rnw = rnw; b_oe_n = oen;
        b_pipe = pp; b_addr = ad; b_wdata = wd;
        @(posedge b_clk);
        #1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge a_clk);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
        summary();
    end

    initial begin
        a_rst_n = 1'b0; b_rst_n = 1'b0;
        a_cs0_n = 1'b1; a_cs1 = 1'b0; a_rnw = 1'b1; a_oe_n = 1'b1; a_pipe = 1'b0;
        b_cs0_n = 1'b1; b_cs1 = 1'b0; b_rnw = 1'b1; b_oe_n = 1'b1; b_pipe = 1'b0;
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
        repeat (4) @(posedge a_clk);
        #1;
        check("R9", "a_drive reset", 16'(a_drive), 16'd0);
        check("R9", "b_drive reset", 16'(b_drive), 16'd0);
        @(negedge a_clk);
        a_rst_n = 1'b1; b_rst_n = 1'b1;

        // Table walk on port A.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            a_op(v.cs0_n, v.cs1, v.rnw, v.oe_n, v.pipe, v.addr, v.wd);
            check($sformatf("R%0d", v.req), $sformatf("row %0d drive", i),
                  16'(a_drive), 16'(v.exp_drv));
            if (v.chk_dat) begin
                check($sformatf("R%0d", v.req), $sformatf("row %0d rdata", i),
                      16'(a_rdata), 16'(v.exp_dat));
            end
        end

        // R8: mode pin acts without a clock (register holds word 6, address reg holds 5).
        a_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'd6, 9'h000);
        a_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'd5, 9'h000);
        check("R8", "registered word", 16'(a_rdata), 16'h0C3);
        a_pipe = 1'b0;
        #1;
        check("R8", "direct word after pin change", 16'(a_rdata), 16'h1A5);
        a_pipe = 1'b1;
        #1;
        check("R8", "registered word restored", 16'(a_rdata), 16'h0C3);

        // R5: asynchronous output enable in direct mode.
        a_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd5, 9'h000);
        check("R5", "drive before oe_n", 16'(a_drive), 16'd1);
        a_oe_n = 1'b1;
        #1;
        check("R5", "drive with oe_n high, no edge", 16'(a_drive), 16'd0);
        a_oe_n = 1'b0;
        #1;
        check("R5", "drive with oe_n low again", 16'(a_drive), 16'd1);

        // R7: cross-port transfer in both directions.
        a_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd20, 9'h133);
        b_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd20, 9'h000);
        check("R7", "B reads A word", 16'(b_rdata), 16'h133);
        check("R7", "B drive", 16'(b_drive), 16'd1);
        b_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 11'd21, 9'h0AA);
        a_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd21, 9'h000);
        check("R7", "A reads B word", 16'(a_rdata), 16'h0AA);
        a_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd20, 9'h044);
        b_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd20, 9'h000);
        check("R7", "B sees rewrite on next read", 16'(b_rdata), 16'h044);

        // R9: both ends of the address range.
        a_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'h7FF, 9'h101);
        a_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'h000, 9'h0FE);
        a_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h7FF, 9'h000);
        check("R9", "top address", 16'(a_rdata), 16'h101);
        a_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h000, 9'h000);
        check("R9", "address zero", 16'(a_rdata), 16'h0FE);
        b_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h7FF, 9'h000);
        check("R9", "top address via B", 16'(b_rdata), 16'h101);

        summary();
    end
endmodule